// File: doc/BRIEF.md
# Sinc3 Decimation Filter

This block turns a one-bit sigma-delta modulator stream into decimated output words. Every accepted modulator bit counts as +1 (bit high) or -1 (bit low). It enters a three-stage integrator cascade. At each decimation instant a three-stage differentiator cascade takes the integrator value, which gives a third-order sinc low-pass response. The decimation ratio is a 12-bit code built from two control fields. The code is clamped to a supported range and can be changed at run time.

The signed filter result is normalised by the filter gain (ratio cubed) in a serial divider. It is then mapped into unipolar straight binary or bipolar offset binary. The result saturates at the code limits. Each output is 24 bits wide, or the top 16 bits of that word right-justified. A change of ratio code, or a resynchronise request, clears all filter state and hides the first three outputs while the filter settles.

The modulator strobe is assumed to arrive no more often than every second clock. In normal use it arrives once every 128 clocks.

Top module: `sinc3_decim`

## Requirements
- R1: After reset, valid_o is low and data_o is zero.
- R2: The ratio code is {filt_hi_i[3:0], filt_lo_i[7:0]}, with filt_hi_i as the upper four bits. One decimation instant occurs every R accepted strobes. A sample is accepted only in a cycle with mod_en_i high, and mod_bit_i has no effect in other cycles.
- R3: The effective ratio R is the code clamped to the range 19 to 4000. Codes below 19 act as 19 and codes above 4000 act as 4000.
- R4: At a decimation instant the signed result y is the sum of the last 3R-2 samples (+1/-1), weighted by the coefficients of the three-fold convolution of a length-R box, with the newest sample at weight index 0. Let q = floor(|y|·2^24 / R^3).
- R5: Unipolar coding (bipolar_i=0): the code is 0 when y<0. Otherwise it is q, clamped to 0xFFFFFF, so a constant-ones stream gives all ones.
- R6: Bipolar coding (bipolar_i=1): the code is 0x800000 + floor(q/2) when y≥0, or 0x800000 - floor(q/2) when y<0. It is clamped to 0xFFFFFF. A constant-zeros stream gives 0x000000 and a zero-mean stream sits near 0x800000.
- R7: With short_i=1, data_o is {8'h00, code[23:8]}.
- R8: Filter state is cleared in the cycle the ratio code differs from its previous value, or when resync_i is high. This also aborts a pending output. Outputs at the first three decimation instants after a clear or reset are suppressed, so the first output follows the 4R-th accepted strobe.
- R9: valid_o is a one-cycle pulse, visible 26 clock edges after the edge that accepts the R-th strobe of a period. data_o holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_en_i | input | 1 | Modulator bit strobe |
| mod_bit_i | input | 1 | Modulator bit |
| filt_hi_i | input | 4 | Upper four bits of the ratio code |
| filt_lo_i | input | 8 | Lower eight bits of the ratio code |
| bipolar_i | input | 1 | 1: offset binary, 0: straight binary |
| short_i | input | 1 | 1: 16-bit right-justified output |
| resync_i | input | 1 | Clear filter state and restart settling |
| data_o | output | 24 | Output word |
| valid_o | output | 1 | Output word valid pulse |

## Verification
The bench drives constant-ones and constant-zeros streams in both codings, which hit the clamp at exactly full scale. A normaliser that rounds instead of saturating would wrap to zero or pass the midpoint on these streams. Ratio codes below and above the clamp range, including the largest ratio, expose missing clamping as a wrong output interval and a gain mismatch. Resynchronising while a result is being divided, and changing the code without a resync, catch a design that lets a stale word out or forgets to hide the three settling outputs. Random mod_bit_i values driven while the strobe is low would disturb the result if samples leaked in outside strobes.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  typedef enum logic {CODING_UNI = 1'b0, CODING_BIP = 1'b1} coding_e;

  function automatic int unsigned clamp_ratio(int unsigned code, int unsigned lo, int unsigned hi);
    if (code < lo) return lo;
    if (code > hi) return hi;
    return code;
  endfunction

  function automatic longint unsigned ipow(longint unsigned b, int e);
    longint unsigned p = 1;
    for (int k = 0; k < e; k++) p = p * b;
    return p;
  endfunction
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int ORDER = 3,
  parameter int ACC_W = 37
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] x;
  assign x = bit_i ? ACC_W'(1) : '1;

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    logic [ACC_W-1:0] acc_q, sum_d;
    if (k == 0) begin : g_first
      assign sum_d = acc_q + x;
    end else begin : g_next
      assign sum_d = acc_q + g_stage[k-1].sum_d;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    acc_q <= '0;
      else if (clr_i) acc_q <= '0;
      else if (en_i)  acc_q <= sum_d;
    end
  end

  assign acc_o = g_stage[ORDER-1].acc_q;
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int ORDER = 3,
  parameter int ACC_W = 37
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] din_i,
  output logic [ACC_W-1:0] dout_o
);
  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    logic [ACC_W-1:0] in_d, dly_q, diff_d;
    if (k == 0) begin : g_first
      assign in_d = din_i;
    end else begin : g_next
      assign in_d = g_stage[k-1].diff_d;
    end
    assign diff_d = in_d - dly_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    dly_q <= '0;
      else if (clr_i) dly_q <= '0;
      else if (en_i)  dly_q <= in_d;
    end
  end

  assign dout_o = g_stage[ORDER-1].diff_d;
endmodule

// File: rtl/sinc3_norm.sv
module sinc3_norm #(
  parameter int ACC_W   = 37,
  parameter int CUBE_W  = 36,
  parameter int OUT_W   = 24,
  parameter int SHORT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              start_i,
  input  logic [ACC_W-1:0]  y_i,
  input  logic [CUBE_W-1:0] cube_i,
  input  logic              bipolar_i,
  input  logic              short_i,
  output logic [OUT_W-1:0]  data_o,
  output logic              valid_o
);
  import sinc3_pkg::*;
  localparam int STEP_W = $clog2(OUT_W + 1);
  localparam int REM_W  = ACC_W + 1;
  localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W - 1);

  logic              busy_q, neg_q, trial;
  logic [STEP_W-1:0] step_q;
  logic [REM_W-1:0]  rem_q, rem_sub, div_ext;
  logic [OUT_W-1:0]  quo_q, uni_code, bip_code, code, fmt;
  logic [OUT_W:0]    q_full, bip_sum;
  logic [ACC_W-1:0]  y_abs;
  coding_e           coding;

  assign coding  = bipolar_i ? CODING_BIP : CODING_UNI;
  assign y_abs   = y_i[ACC_W-1] ? (~y_i + 1'b1) : y_i;
  assign div_ext = REM_W'(cube_i);
  assign trial   = rem_q >= div_ext;
  assign rem_sub = trial ? (rem_q - div_ext) : rem_q;
  assign q_full  = {quo_q, trial};

  // saturate at all ones, negative unipolar results floor at zero
  assign uni_code = neg_q ? '0 : (q_full[OUT_W] ? '1 : q_full[OUT_W-1:0]);
  assign bip_sum  = {1'b0, MID} + {1'b0, q_full[OUT_W:1]};
  assign bip_code = neg_q ? (MID - q_full[OUT_W:1]) :
                    (bip_sum[OUT_W] ? '1 : bip_sum[OUT_W-1:0]);
  assign code     = (coding == CODING_BIP) ? bip_code : uni_code;
  assign fmt      = short_i ? OUT_W'(code[OUT_W-1:OUT_W-SHORT_W]) : code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      neg_q   <= 1'b0;
      step_q  <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (start_i) begin
        busy_q <= 1'b1;
        neg_q  <= y_i[ACC_W-1];
        rem_q  <= REM_W'(y_abs);
        step_q <= '0;
        quo_q  <= '0;
      end else if (busy_q) begin
        rem_q  <= rem_sub << 1;
        quo_q  <= q_full[OUT_W-1:0];
        step_q <= step_q + 1'b1;
        if (step_q == STEP_W'(OUT_W)) begin
          busy_q  <= 1'b0;
          valid_o <= 1'b1;
          data_o  <= fmt;
        end
      end
    end
  end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
  parameter int HI_W      = 4,
  parameter int LO_W      = 8,
  parameter int OUT_W     = 24,
  parameter int SHORT_W   = 16,
  parameter int ORDER     = 3,
  parameter int MIN_RATIO = 19,
  parameter int MAX_RATIO = 4000,
  parameter int SETTLE    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mod_en_i,
  input  logic             mod_bit_i,
  input  logic [HI_W-1:0]  filt_hi_i,
  input  logic [LO_W-1:0]  filt_lo_i,
  input  logic             bipolar_i,
  input  logic             short_i,
  input  logic             resync_i,
  output logic [OUT_W-1:0] data_o,
  output logic             valid_o
);
  import sinc3_pkg::*;
  localparam int CODE_W = HI_W + LO_W;
  localparam int CUBE_W = ORDER * CODE_W;
  localparam int ACC_W  = CUBE_W + 1;
  localparam int SET_W  = $clog2(SETTLE + 1);
  localparam logic [CUBE_W-1:0] MIN_CUBE = CUBE_W'(ipow(longint'(MIN_RATIO), ORDER));

  logic [CODE_W-1:0] code_raw, code_q, ratio_d, ratio_q, smp_q;
  logic [CUBE_W-1:0] cube_d, cube_q;
  logic [ACC_W-1:0]  integ_out, comb_out;
  logic [SET_W-1:0]  settle_q;
  logic              clr, code_chg, dec_tick, start;

  assign code_raw = {filt_hi_i, filt_lo_i};
  assign code_chg = code_raw != code_q;
  assign clr      = code_chg | resync_i;
  assign ratio_d  = CODE_W'(clamp_ratio(32'(code_raw), MIN_RATIO, MAX_RATIO));

  always_comb begin
    cube_d = CUBE_W'(1);
    for (int k = 0; k < ORDER; k++) cube_d = cube_d * CUBE_W'(ratio_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      ratio_q <= CODE_W'(MIN_RATIO);
      cube_q  <= MIN_CUBE;
    end else if (code_chg) begin
      code_q  <= code_raw;
      ratio_q <= ratio_d;
      cube_q  <= cube_d;
    end
  end

  // sample counter, decimation tick and settling count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q    <= '0;
      dec_tick <= 1'b0;
      settle_q <= '0;
    end else if (clr) begin
      smp_q    <= '0;
      dec_tick <= 1'b0;
      settle_q <= '0;
    end else begin
      dec_tick <= 1'b0;
      if (mod_en_i) begin
        if (smp_q == ratio_q - 1'b1) begin
          smp_q    <= '0;
          dec_tick <= 1'b1;
        end else begin
          smp_q <= smp_q + 1'b1;
        end
      end
      if (dec_tick && settle_q != SET_W'(SETTLE)) settle_q <= settle_q + 1'b1;
    end
  end

  assign start = dec_tick && (settle_q == SET_W'(SETTLE)) && !clr;

  sinc3_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .en_i  (mod_en_i),
    .bit_i (mod_bit_i),
    .acc_o (integ_out)
  );

  sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .en_i  (dec_tick),
    .din_i (integ_out),
    .dout_o(comb_out)
  );

  sinc3_norm #(.ACC_W(ACC_W), .CUBE_W(CUBE_W), .OUT_W(OUT_W), .SHORT_W(SHORT_W)) u_norm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .abort_i  (clr),
    .start_i  (start),
    .y_i      (comb_out),
    .cube_i   (cube_q),
    .bipolar_i(bipolar_i),
    .short_i  (short_i),
    .data_o   (data_o),
    .valid_o  (valid_o)
  );
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
  parameter int HI_W      = 4,
  parameter int LO_W      = 8,
  parameter int OUT_W     = 24,
  parameter int SHORT_W   = 16,
  parameter int MIN_RATIO = 19,
  parameter int MAX_RATIO = 4000,
  parameter int SETTLE    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mod_en_i,
  input logic [HI_W-1:0]  filt_hi_i,
  input logic [LO_W-1:0]  filt_lo_i,
  input logic             short_i,
  input logic             resync_i,
  input logic [OUT_W-1:0] data_o,
  input logic             valid_o
);
  import sinc3_pkg::*;
  localparam int CODE_W = HI_W + LO_W;
  localparam int CNT_W  = CODE_W + 4;

  logic [CODE_W-1:0] code_prev, code_now;
  logic [CNT_W-1:0]  strb_cnt;
  logic              clr;
  int unsigned       need;

  assign code_now = {filt_hi_i, filt_lo_i};
  assign clr      = (code_now != code_prev) | resync_i;
  assign need     = (SETTLE + 1) * clamp_ratio(32'(code_prev), MIN_RATIO, MAX_RATIO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_prev <= '0;
      strb_cnt  <= '0;
    end else begin
      code_prev <= code_now;
      if (clr) strb_cnt <= '0;
      else if (mod_en_i && strb_cnt != '1) strb_cnt <= strb_cnt + 1'b1;
    end
  end

  AST_NO_EARLY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> 32'(strb_cnt) >= need); // R8
  AST_ABORT_ON_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> !valid_o); // R8
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R9
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o)); // R9
  AST_SHORT_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(short_i)) |-> data_o[OUT_W-1:SHORT_W] == '0); // R7
endmodule

bind sinc3_decim sinc3_decim_chk #(
  .HI_W(HI_W), .LO_W(LO_W), .OUT_W(OUT_W), .SHORT_W(SHORT_W),
  .MIN_RATIO(MIN_RATIO), .MAX_RATIO(MAX_RATIO), .SETTLE(SETTLE)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mod_en_i (mod_en_i),
  .filt_hi_i(filt_hi_i),
  .filt_lo_i(filt_lo_i),
  .short_i  (short_i),
  .resync_i (resync_i),
  .data_o   (data_o),
  .valid_o  (valid_o)
);

// File: tb/sinc3_decim_test.sv
`timescale 1ns/1ps
module sinc3_decim_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b0, mod_bit = 1'b0;
  logic [3:0]  filt_hi = '0;
  logic [7:0]  filt_lo = '0;
  logic        bipolar = 1'b0, shrt = 1'b0, resync = 1'b0;
  logic [23:0] data_o;
  logic        valid_o;

  always #4 clk = ~clk;

  sinc3_decim uut (
    .clk_i(clk), .rst_ni(rst_n), .mod_en_i(mod_en), .mod_bit_i(mod_bit),
    .filt_hi_i(filt_hi), .filt_lo_i(filt_lo), .bipolar_i(bipolar),
    .short_i(shrt), .resync_i(resync), .data_o(data_o), .valid_o(valid_o)
  );

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural model state
  int     hist[$];
  longint h[];
  int     ratio = 0, scnt = 0, nout = 0;
  longint cube = 1;
  bit     m_bip = 0, m_short = 0;
  string  tag = "R1";
  longint      exp_due[$];
  logic [23:0] exp_val[$];
  string       exp_tag[$];

  function automatic int clampr(int code);
    return code < 19 ? 19 : (code > 4000 ? 4000 : code);
  endfunction

  function automatic void build_h(int r);
    longint h2[];
    h2 = new[2*r-1];
    foreach (h2[i]) h2[i] = 0;
    for (int i = 0; i < r; i++) for (int j = 0; j < r; j++) h2[i+j] += 1;
    h = new[3*r-2];
    foreach (h[i]) h[i] = 0;
    for (int i = 0; i < 2*r-1; i++) for (int j = 0; j < r; j++) h[i+j] += h2[i];
  endfunction

  function automatic logic [23:0] expect_code(longint y);
    longint ay, q, c;
    ay = (y < 0) ? -y : y;
    q  = (ay <<< 24) / cube;
    if (!m_bip) c = (y < 0) ? 0 : ((q > 64'd16777215) ? 16777215 : q);
    else begin
      c = (y < 0) ? (8388608 - (q >>> 1)) : (8388608 + (q >>> 1));
      if (c > 16777215) c = 16777215;
      if (c < 0) c = 0;
    end
    if (m_short) c = c >>> 8;
    return c[23:0];
  endfunction

  task automatic tick();
    @(negedge clk);
    if (exp_due.size() > 0 && exp_due[0] == cyc) begin
      checks++;
      if (!valid_o) begin
        failures++;
        $display("FAIL %s R9: valid_o=0 expected 1 at cycle %0d", exp_tag[0], cyc);
      end else if (data_o !== exp_val[0]) begin
        failures++;
        $display("FAIL %s: data_o=%h expected %h", exp_tag[0], data_o, exp_val[0]);
      end
      void'(exp_due.pop_front()); void'(exp_val.pop_front()); void'(exp_tag.pop_front());
    end else if (valid_o) begin
      checks++; failures++;
      $display("FAIL R8 R9 (%s): valid_o=1 data_o=%h expected no output at cycle %0d", tag, data_o, cyc);
    end
  endtask

  task automatic model_clear();
    hist.delete(); scnt = 0; nout = 0;
    exp_due.delete(); exp_val.delete(); exp_tag.delete();
  endtask

  task automatic model_sample(bit b);
    longint y;
    hist.push_back(b ? 1 : -1);
    if (hist.size() > 3*ratio) void'(hist.pop_front());
    scnt++;
    if (scnt == ratio) begin
      scnt = 0; nout++;
      if (nout > 3) begin
        y = 0;
        for (int j = 0; j < h.size() && j < hist.size(); j++) y += h[j] * hist[hist.size()-1-j];
        exp_due.push_back(cyc + 27);
        exp_val.push_back(expect_code(y));
        exp_tag.push_back(tag);
      end
    end
  endtask

  task automatic set_ratio(int code);
    if (clampr(code) != ratio) begin
      ratio = clampr(code);
      cube  = longint'(ratio) * ratio * ratio;
      build_h(ratio);
    end
  endtask

  task automatic configure(int code, bit bip, bit sh, string t);
    tick();
    filt_hi = code[11:8]; filt_lo = code[7:0]; bipolar = bip; shrt = sh; resync = 1'b1;
    m_bip = bip; m_short = sh; tag = t;
    model_clear(); set_ratio(code);
    tick();
    resync = 1'b0;
  endtask

  task automatic change_code(int code, string t);
    tick();
    filt_hi = code[11:8]; filt_lo = code[7:0]; tag = t;
    model_clear(); set_ratio(code);
  endtask

  task automatic feed(bit b, int gap);
    tick();
    mod_en = 1'b1; mod_bit = b;
    model_sample(b);
    tick();
    mod_en = 1'b0; mod_bit = 1'($urandom);  // R2: ignored while strobe low
    repeat (gap - 2) tick();
  endtask

  // mode: 0 ones, 1 zeros, 2 alternate, 3 density 3/4, 4 density 1/4, 5 density 1/2
  task automatic run(int n, int mode, int gap);
    for (int i = 0; i < n; i++) begin
      bit b;
      case (mode)
        0: b = 1'b1;
        1: b = 1'b0;
        2: b = i[0];
        3: b = ($urandom % 4) != 0;
        4: b = ($urandom % 4) == 0;
        default: b = 1'($urandom);
      endcase
      feed(b, gap);
    end
  endtask

  task automatic drain();
    repeat (40) tick();
    checks++;
    if (exp_due.size() != 0) begin
      failures++;
      $display("FAIL %s R9: %0d outputs outstanding expected 0", tag, exp_due.size());
      model_clear();
    end
  endtask

  initial begin
    ratio = 19; cube = 6859; build_h(19);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    checks++;
    if (valid_o !== 1'b0) begin failures++; $display("FAIL R1: valid_o=%b expected 0", valid_o); end
    checks++;
    if (data_o !== 24'h0) begin failures++; $display("FAIL R1: data_o=%h expected 000000", data_o); end

    // R5 unipolar full scale and zero
    configure(20, 0, 0, "R5"); run(6*20, 0, 4); drain();
    configure(20, 0, 0, "R5"); run(6*20, 1, 4); drain();
    // R6 bipolar extremes and midscale
    configure(24, 1, 0, "R6"); run(6*24, 0, 4); drain();
    configure(24, 1, 0, "R6"); run(6*24, 1, 4); drain();
    configure(24, 1, 0, "R6"); run(6*24, 2, 4); drain();
    // R4 response under random densities
    configure(37, 1, 0, "R4"); run(8*37, 3, 4); drain();
    configure(37, 0, 0, "R4"); run(8*37, 5, 4); drain();
    // R7 short word
    configure(30, 1, 1, "R7"); run(6*30, 4, 4); drain();
    configure(30, 0, 1, "R7"); run(6*30, 0, 4); drain();
    // R2 upper code bits in use
    configure(12'h12C, 1, 0, "R2"); run(5*300, 4, 2); drain();
    // R3 clamping at both ends
    configure(5, 1, 0, "R3"); run(6*19, 3, 4); drain();
    configure(12'hFFF, 1, 0, "R3"); run(5*4000, 5, 2); drain();
    // R8 resync while a result is being normalised, then code change alone
    configure(22, 1, 0, "R8"); run(4*22 + 3, 3, 4);
    configure(22, 1, 0, "R8"); run(5*22, 3, 4); drain();
    run(7, 5, 4);
    change_code(26, "R8"); run(5*26, 4, 4); drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    done = 1;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule